// File: doc/BRIEF.md
# DRAM Activate-Rate Gate

This block sits inside a DRAM command scheduler and answers one question each clock cycle: may the pending row-activate command go out now? It enforces two rate limits at once. Successive activates must be a minimum number of cycles apart (the row-to-row spacing). No more than four activates may fall inside any sliding window of a programmable length (the four-activate window). On top of both limits, no activate is allowed while the refresh-busy flag is high.

The scheduler raises `act_req` and holds it until `act_grant` answers in the same cycle. Whenever a request is held back, `stall_why` names the constraint that blocks it. The two timing values arrive on configuration inputs and are captured only while the block is still idle after reset. Values below the legal minimums are raised to those minimums.

Top module: `act_rate_gate`

## Requirements
- R1: Two consecutive grants are always at least the effective spacing value (`cfg_rrd` after clamping) cycles apart; a grant in cycle t allows the next one no earlier than cycle t+spacing.
- R2: Any run of window-length cycles (`cfg_faw` after clamping) holds at most four grants. A fifth grant is held until the oldest of the last four grants is at least window-length cycles in the past.
- R3: When the effective window equals exactly four times the effective spacing, a request held high continuously is granted every spacing cycles, with no extra stall.
- R4: When the window is longer than four times the spacing, a held request gets an extra gap after each group of four grants. With spacing 4 and window 20, the grants fall at offsets 0, 4, 8, 12 and 20.
- R5: `act_grant` is never high while `refresh_busy` is high.
- R6: `act_grant` is combinational. It is high in the same cycle that `act_req` is high and no constraint blocks, and it is never high without `act_req`.
- R7: `stall_why` is 0 when there is no request or the request is granted. Otherwise it reports the highest-priority blocking constraint: 3 for refresh (highest), then 2 for the window, then 1 for spacing.
- R8: A spacing value below 4 is treated as 4. A window value below four times the effective spacing is treated as four times the effective spacing, so the smallest effective window is 16.
- R9: The configuration inputs are sampled while reset is high and in every cycle before the first grant after reset. Changes made after the first grant have no effect until the next reset.
- R10: Reset clears all activate history, so a request in the first cycle after reset is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_req | input | 1 | Pending row-activate request, held until granted |
| refresh_busy | input | 1 | High while a refresh is in progress |
| cfg_rrd | input | RRD_W | Minimum activate spacing in cycles |
| cfg_faw | input | FAW_W | Four-activate window length in cycles |
| act_grant | output | 1 | Activate may issue this cycle |
| stall_why | output | 2 | Blocking reason: 0 none, 1 spacing, 2 window, 3 refresh |

## Verification
If a slot in the window ring held the wrong remaining count, or the ring pointer slipped, the fifth grant of a saturated burst would appear a few cycles early or late. The gate would also report window stalls in cycles where only spacing should block. The error shows at the ports within one window length of the grant that corrupted it. A spacing counter loaded with the wrong value moves the very next grant, and configuration that is still open to change after the first grant changes the grant cadence within one spacing period. The bench compares grant and stall reason against an independent cycle-accurate model in every cycle, so any of these faults is reported in the first cycle where the outputs differ.

// File: rtl/act_gate_pkg.sv
package act_gate_pkg;

  // Stall reason code, higher value means higher priority
  typedef enum logic [1:0] {
    STALL_NONE    = 2'd0,
    STALL_SPACING = 2'd1,
    STALL_WINDOW  = 2'd2,
    STALL_REFRESH = 2'd3
  } stall_e;

endpackage

// File: rtl/act_cfg_latch.sv
module act_cfg_latch #(
  parameter int RRD_W     = 6,
  parameter int FAW_W     = 8,
  parameter int MIN_RRD   = 4,
  parameter int ACT_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [RRD_W-1:0] rrd_in,
  input  logic [FAW_W-1:0] faw_in,
  output logic [RRD_W-1:0] rrd_q,
  output logic [FAW_W-1:0] faw_q,
  output logic             locked
);

  logic [RRD_W-1:0] rrd_c;
  logic [FAW_W-1:0] faw_floor;
  logic [FAW_W-1:0] faw_c;

  // Raise both settings to their legal floors
  always_comb begin
    rrd_c     = (int'(rrd_in) < MIN_RRD) ? RRD_W'(MIN_RRD) : rrd_in;
    faw_floor = FAW_W'(ACT_LIMIT * int'(rrd_c));
    faw_c     = (faw_in < faw_floor) ? faw_floor : faw_in;
  end

  // Settings follow the inputs until the first grant, then freeze
  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      rrd_q  <= rrd_c;
      faw_q  <= faw_c;
    end else begin
      if (fire) locked <= 1'b1;
      if (!locked && !fire) begin
        rrd_q <= rrd_c;
        faw_q <= faw_c;
      end
    end
  end

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(rrd_q) && $stable(faw_q)));

  p_cfg_floor_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(rrd_q) >= MIN_RRD) && (int'(faw_q) >= ACT_LIMIT * int'(rrd_q)));

endmodule

// File: rtl/act_spacing_timer.sv
module act_spacing_timer #(
  parameter int RRD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [RRD_W-1:0] rrd_q,
  output logic             ready
);

  logic [RRD_W-1:0] rem;

  // Cycles left before another grant may follow the last one
  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (fire) begin
      rem <= rrd_q - RRD_W'(1);
    end else if (rem != '0) begin
      rem <= rem - RRD_W'(1);
    end
  end

  assign ready = (rem == '0);

  p_spacing_bound_r1: assert property (@(posedge clk) disable iff (rst)
    rem < rrd_q);

endmodule

// File: rtl/act_window_tracker.sv
module act_window_tracker #(
  parameter int FAW_W     = 8,
  parameter int ACT_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [FAW_W-1:0] faw_q,
  output logic             ready
);

  localparam int PTR_W = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;

  logic [FAW_W-1:0] rem [ACT_LIMIT];
  logic [PTR_W-1:0] ptr;

  // ptr marks the oldest grant, which is also the next slot to reuse
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (fire) begin
      ptr <= (int'(ptr) == ACT_LIMIT - 1) ? '0 : ptr + PTR_W'(1);
    end
  end

  for (genvar g = 0; g < ACT_LIMIT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        rem[g] <= '0;
      end else if (fire && (int'(ptr) == g)) begin
        rem[g] <= faw_q - FAW_W'(1);
      end else if (rem[g] != '0) begin
        rem[g] <= rem[g] - FAW_W'(1);
      end
    end

    // The oldest slot always expires first
    p_oldest_first_r2: assert property (@(posedge clk) disable iff (rst)
      rem[ptr] <= rem[g]);
  end

  assign ready = (rem[ptr] == '0);

endmodule

// File: rtl/act_rate_gate.sv
module act_rate_gate
  import act_gate_pkg::*;
#(
  parameter int RRD_W     = 6,
  parameter int FAW_W     = RRD_W + 2,
  parameter int MIN_RRD   = 4,
  parameter int ACT_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_req,
  input  logic             refresh_busy,
  input  logic [RRD_W-1:0] cfg_rrd,
  input  logic [FAW_W-1:0] cfg_faw,
  output logic             act_grant,
  output logic [1:0]       stall_why
);

  logic [RRD_W-1:0] rrd_q;
  logic [FAW_W-1:0] faw_q;
  logic             locked;
  logic             sp_ready;
  logic             win_ready;
  stall_e           why;

  act_cfg_latch #(
    .RRD_W(RRD_W), .FAW_W(FAW_W), .MIN_RRD(MIN_RRD), .ACT_LIMIT(ACT_LIMIT)
  ) u_cfg (
    .clk(clk), .rst(rst), .fire(act_grant),
    .rrd_in(cfg_rrd), .faw_in(cfg_faw),
    .rrd_q(rrd_q), .faw_q(faw_q), .locked(locked)
  );

  act_spacing_timer #(.RRD_W(RRD_W)) u_space (
    .clk(clk), .rst(rst), .fire(act_grant), .rrd_q(rrd_q), .ready(sp_ready)
  );

  act_window_tracker #(.FAW_W(FAW_W), .ACT_LIMIT(ACT_LIMIT)) u_win (
    .clk(clk), .rst(rst), .fire(act_grant), .faw_q(faw_q), .ready(win_ready)
  );

  always_comb begin
    act_grant = act_req && !refresh_busy && sp_ready && win_ready;
    if (!act_req || act_grant) why = STALL_NONE;
    else if (refresh_busy)     why = STALL_REFRESH;
    else if (!win_ready)       why = STALL_WINDOW;
    else                       why = STALL_SPACING;
  end

  assign stall_why = why;

  // Checker: cycles since last grant, counted apart from the spacing timer
  logic [FAW_W:0] gap;
  logic           seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (act_grant) begin
      gap  <= (FAW_W+1)'(1);
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap  <= gap + (FAW_W+1)'(1);
    end
  end

  p_gap_min_r1: assert property (@(posedge clk) disable iff (rst)
    (act_grant && seen) |-> (int'(gap) >= int'(rrd_q)));

  p_refresh_block_r5: assert property (@(posedge clk) disable iff (rst)
    refresh_busy |-> !act_grant);

  p_grant_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    act_grant |-> act_req);

  p_reason_refresh_r7: assert property (@(posedge clk) disable iff (rst)
    (act_req && refresh_busy) |-> (stall_why == 2'd3));

  p_first_free_r10: assert property (@(posedge clk) disable iff (rst)
    (!locked && act_req && !refresh_busy) |-> act_grant);

endmodule

// File: tb/tb_act_rate_gate.sv
module tb_act_rate_gate;

  localparam int RRD_W = 6;
  localparam int FAW_W = RRD_W + 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             act_req = 1'b0;
  logic             refresh_busy = 1'b0;
  logic [RRD_W-1:0] cfg_rrd = 6'd4;
  logic [FAW_W-1:0] cfg_faw = 8'd16;
  logic             act_grant;
  logic [1:0]       stall_why;

  act_rate_gate #(.RRD_W(RRD_W), .FAW_W(FAW_W)) dut (
    .clk(clk), .rst(rst), .act_req(act_req), .refresh_busy(refresh_busy),
    .cfg_rrd(cfg_rrd), .cfg_faw(cfg_faw),
    .act_grant(act_grant), .stall_why(stall_why)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state
  int cyc, last_g, hcount, hptr, eff_rrd, eff_faw;
  int hist [4];
  bit mlocked;
  int glog [16];
  int gcount;

  function automatic int clamp_rrd(int v);
    return (v < 4) ? 4 : v;
  endfunction

  function automatic int clamp_faw(int v, int r);
    return (v < 4 * r) ? 4 * r : v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset(int r, int f);
    @(negedge clk);
    cfg_rrd = RRD_W'(r);
    cfg_faw = FAW_W'(f);
    act_req = 1'b0;
    refresh_busy = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc = 0; last_g = -1; hcount = 0; hptr = 0; mlocked = 0; gcount = 0;
    eff_rrd = clamp_rrd(r);
    eff_faw = clamp_faw(f, eff_rrd);
  endtask

  // One cycle: drive at the falling edge, compare, then let the rising edge pass
  task automatic step(bit rq, bit rf, string tag);
    bit sok, wok, eg;
    int er;
    if (!mlocked) begin
      eff_rrd = clamp_rrd(int'(cfg_rrd));
      eff_faw = clamp_faw(int'(cfg_faw), eff_rrd);
    end
    act_req = rq;
    refresh_busy = rf;
    #1;
    sok = (last_g < 0) || (cyc - last_g >= eff_rrd);
    wok = (hcount < 4) || (cyc - hist[hptr] >= eff_faw);
    eg  = rq && !rf && sok && wok;
    if (!rq || eg) er = 0;
    else if (rf)   er = 3;
    else if (!wok) er = 2;
    else           er = 1;
    check({tag, " grant R1 R2 R5 R6"}, int'(act_grant), int'(eg));
    check({tag, " reason R7"}, int'(stall_why), er);
    if (eg) begin
      last_g = cyc;
      hist[hptr] = cyc;
      hptr = (hptr + 1) % 4;
      if (hcount < 4) hcount++;
      mlocked = 1;
      if (gcount < 16) glog[gcount] = cyc;
      gcount++;
    end
    @(negedge clk);
    cyc++;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit pend;
    void'($urandom(32'd20240611));

    // R10: reset state and immediate first grant; R4: extra window gap
    do_reset(4, 20);
    #1;
    check("reset grant R10", int'(act_grant), 0);
    check("reset reason R10", int'(stall_why), 0);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "sat4_20");
    check("first grant offset R10", glog[0], 0);
    check("fourth grant offset R4", glog[3], 12);
    check("fifth grant offset R4", glog[4], 20);

    // R3: window exactly four spacings adds nothing
    do_reset(4, 16);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "sat4_16");
    check("fifth grant offset R3", glog[4], 16);
    check("ninth grant offset R3", glog[8], 32);

    // R8: clamp of too-small settings
    do_reset(1, 3);
    for (int i = 0; i < 25; i++) step(1'b1, 1'b0, "clamp");
    check("clamped spacing R8", glog[1] - glog[0], 4);
    check("clamped window R8", glog[4], 16);

    // R8: window raised to four times a larger spacing
    do_reset(6, 10);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "clamp6");
    check("window floor 24 R8", glog[4], 24);

    // R9: settings changed after first grant are ignored
    do_reset(4, 16);
    step(1'b1, 1'b0, "lock");
    cfg_rrd = 6'd12;
    cfg_faw = 8'd90;
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0, "lock");
    check("cadence after cfg change R9", glog[2] - glog[1], 4);
    check("fifth after cfg change R9", glog[4], 16);

    // R5, R7: refresh holds a waiting request
    do_reset(5, 30);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, "refresh");
    check("no grant under refresh R5", gcount, 0);
    step(1'b1, 1'b0, "refresh_end");
    check("grant after refresh R5", gcount, 1);

    // Random traffic with held requests and refresh bursts
    for (int s = 0; s < 6; s++) begin
      int rb;
      do_reset(int'($urandom_range(0, 12)), int'($urandom_range(0, 90)));
      pend = 0;
      rb = 0;
      for (int i = 0; i < 2500; i++) begin
        bit rf;
        if (!pend) pend = ($urandom_range(0, 2) != 0);
        if (rb == 0 && $urandom_range(0, 40) == 0) rb = int'($urandom_range(2, 9));
        rf = (rb != 0);
        if (rb != 0) rb--;
        step(pend, rf, "random");
        if (gcount > 0 && last_g == cyc - 1) pend = 0;
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule